// File: doc/BRIEF.md
# Channel Health Monitor with Interrupt

This block watches the health of eight measurement channels. For every channel it receives three raw indications: the signal is present, the excitation is present, and the last self-test accuracy check passed. It turns these into three software-visible status words, one bit per channel. A lost signal or lost excitation counts as a failure only after it has persisted for a qualification time, measured in ticks of an external timebase. A failure stays latched in its status word until software reads that word. Channels that software has not marked active always read as failed.

The block also keeps an interrupt status word with one bit per failure cause. Each cause has its own enable bit. A single interrupt line is raised while any enabled cause bit is set. The cause bits clear when the interrupt status word is read.

When either off-line test mode is on, the signal and excitation watch is suspended. While the background test is on, the block reloads a verify word with 55h on every timebase tick. Software can clear this word and later read it again to confirm that the background test is alive. There is no data stream here: all pins are plain control and status levels or single-cycle strobes. A read strobe acts on the clock edge that ends the cycle in which it is high, and the status value visible during that cycle is the value being read.

Top module: `chan_health_irq`

## Requirements
- R1: Each status word (`sig_stat`, `exc_stat`, `test_stat`) carries channel 1 in bit 0 up to channel 8 in bit 7. A 1 means healthy and a 0 means failed or lost.
- R2: A channel whose bit in `active_mask` is 0 reads 0 in all three status words, whatever its raw inputs are.
- R3: A low `sig_ok_raw` or `exc_ok_raw` bit counts as a loss only once `QUAL_TICKS` ticks have been seen while it stayed low. If the input returns high before that, the count restarts from zero.
- R4: A failure clears the channel's bit in the status word and holds it at 0 until that word's read strobe. After the read, the bit shows the live condition.
- R5: The interrupt cause bits are: bit 0 for signal loss, bit 1 for excitation loss, bit 3 for test accuracy error. Bit 2 always reads 0. The enable word is written with `irq_en_wdata` using the same bit positions. A cause bit is set when an active channel newly enters that failure while the cause is enabled.
- R6: Interrupt cause bits stay set until the `rd_irq_stat` strobe and are cleared by it. A second read with no new failure returns 0.
- R7: While `init_test_en` or `loop_test_en` is high, signal and excitation failures are neither detected nor qualified, and their counts are held at zero.
- R8: While `bg_test_en` is high, each tick loads `verify_reg` with 55h. A `verify_wr` strobe loads `verify_wdata` and takes priority over the reload.
- R9: A test accuracy failure is a low `test_ok_raw` bit while `bg_test_en` or `init_test_en` is high. It needs no qualification time. When neither test is running, `test_ok_raw` has no effect.
- R10: If a new failure and the read strobe of the same status word fall in the same cycle, the failure wins and the bit stays latched at 0.
- R11: `irq_out` is high exactly when a cause bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Qualification timebase strobe |
| sig_ok_raw | input | NUM_CH | Raw signal-present per channel |
| exc_ok_raw | input | NUM_CH | Raw excitation-present per channel |
| test_ok_raw | input | NUM_CH | Raw self-test accuracy pass per channel |
| active_mask | input | NUM_CH | Channels in use |
| bg_test_en | input | 1 | Background on-line test running |
| init_test_en | input | 1 | Initiated off-line self-test running |
| loop_test_en | input | 1 | Off-line interface loop test running |
| rd_sig_stat | input | 1 | Read strobe for signal status |
| rd_exc_stat | input | 1 | Read strobe for excitation status |
| rd_test_stat | input | 1 | Read strobe for test status |
| rd_irq_stat | input | 1 | Read strobe for interrupt status |
| irq_en_wr | input | 1 | Write strobe for the enable word |
| irq_en_wdata | input | 4 | Enable word write data |
| verify_wr | input | 1 | Write strobe for the verify word |
| verify_wdata | input | 8 | Verify word write data |
| sig_stat | output | NUM_CH | Signal status, 1 = healthy |
| exc_stat | output | NUM_CH | Excitation status, 1 = healthy |
| test_stat | output | NUM_CH | Test accuracy status, 1 = healthy |
| irq_stat | output | 4 | Interrupt cause bits |
| irq_enable | output | 4 | Interrupt enable word |
| verify_reg | output | 8 | Background test verify word |
| irq_out | output | 1 | Interrupt line |

## Verification
The block hides little state, and each piece of it reaches the ports quickly. A qualification counter that runs fast, runs slow or fails to restart moves the falling edge of a status bit away from the tick on which it is expected, so a wrong count shows within one tick. A latch that does not hold, or does not release, shows on the first cycle after a read strobe. A missed or doubled cause event shows on the interrupt status word and the line one cycle after the failure appears. The bench therefore compares every output on every cycle against a behavioural model, under both directed and random stimulus.

// File: rtl/chp_pkg.sv
package chp_pkg;
  localparam int IRQ_W      = 4;
  localparam int CAUSE_SIG  = 0;
  localparam int CAUSE_EXC  = 1;
  localparam int CAUSE_TEST = 3;
  localparam logic [IRQ_W-1:0] IRQ_VALID = 4'b1011;
  localparam logic [7:0] VERIFY_PATTERN = 8'h55;
  localparam int NUM_KINDS  = 3;
  typedef enum logic [1:0] {KIND_SIG = 2'd0, KIND_EXC = 2'd1, KIND_TEST = 2'd2} stat_kind_e;
endpackage

// File: rtl/chp_loss_qual.sv
module chp_loss_qual #(
  parameter int QUAL_TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ok_raw,
  input  logic hold_off,
  output logic lost
);
  localparam int CW = $clog2(QUAL_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_TICKS);

  logic [CW-1:0] cnt_q;

  // counts ticks of continuous badness; restarts on recovery or suspension
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ok_raw || hold_off) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lost = (cnt_q == LIMIT) && !hold_off;
endmodule

// File: rtl/chp_sticky_status.sv
module chp_sticky_status #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] fail_now,
  input  logic [NUM_CH-1:0] active,
  input  logic              rd_release,
  output logic [NUM_CH-1:0] status,
  output logic [NUM_CH-1:0] new_fail
);
  logic [NUM_CH-1:0] latch_q;
  logic [NUM_CH-1:0] seen_q;

  // a failure in the read cycle re-arms the latch (failure wins)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      seen_q  <= '0;
    end else begin
      latch_q <= fail_now | (latch_q & ~{NUM_CH{rd_release}});
      seen_q  <= fail_now;
    end
  end

  assign status   = active & ~(latch_q | fail_now);
  assign new_fail = fail_now & ~seen_q & active;
endmodule

// File: rtl/chp_irq_unit.sv
module chp_irq_unit
  import chp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] cause_evt,
  input  logic             en_wr,
  input  logic [IRQ_W-1:0] en_wdata,
  input  logic             rd_stat,
  output logic [IRQ_W-1:0] stat,
  output logic [IRQ_W-1:0] enable,
  output logic             irq
);
  logic [IRQ_W-1:0] stat_q;
  logic [IRQ_W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      if (en_wr) begin
        en_q <= en_wdata & IRQ_VALID;
      end
      stat_q <= (stat_q & ~{IRQ_W{rd_stat}}) | (cause_evt & en_q);
    end
  end

  assign stat   = stat_q;
  assign enable = en_q;
  assign irq    = |(stat_q & en_q);
endmodule

// File: rtl/chp_verify_reg.sv
module chp_verify_reg
  import chp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bg_on,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] value
);
  logic [7:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (wr) begin
      val_q <= wdata;
    end else if (bg_on && tick) begin
      val_q <= VERIFY_PATTERN;
    end
  end

  assign value = val_q;
endmodule

// File: rtl/chan_health_irq.sv
module chan_health_irq
  import chp_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int QUAL_TICKS = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NUM_CH-1:0] sig_ok_raw,
  input  logic [NUM_CH-1:0] exc_ok_raw,
  input  logic [NUM_CH-1:0] test_ok_raw,
  input  logic [NUM_CH-1:0] active_mask,
  input  logic              bg_test_en,
  input  logic              init_test_en,
  input  logic              loop_test_en,
  input  logic              rd_sig_stat,
  input  logic              rd_exc_stat,
  input  logic              rd_test_stat,
  input  logic              rd_irq_stat,
  input  logic              irq_en_wr,
  input  logic [3:0]        irq_en_wdata,
  input  logic              verify_wr,
  input  logic [7:0]        verify_wdata,
  output logic [NUM_CH-1:0] sig_stat,
  output logic [NUM_CH-1:0] exc_stat,
  output logic [NUM_CH-1:0] test_stat,
  output logic [3:0]        irq_stat,
  output logic [3:0]        irq_enable,
  output logic [7:0]        verify_reg,
  output logic              irq_out
);
  logic suspend;
  logic test_running;
  logic [NUM_CH-1:0] sig_lost;
  logic [NUM_CH-1:0] exc_lost;
  logic [NUM_CH-1:0] fail_vec [NUM_KINDS];
  logic [NUM_CH-1:0] stat_vec [NUM_KINDS];
  logic [NUM_CH-1:0] rise_vec [NUM_KINDS];
  logic              rd_vec   [NUM_KINDS];
  logic [IRQ_W-1:0]  cause_evt;

  assign suspend      = init_test_en | loop_test_en;
  assign test_running = bg_test_en | init_test_en;

  // per-channel persistence qualifiers for the two analog loss kinds
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_qual
    chp_loss_qual #(.QUAL_TICKS(QUAL_TICKS)) u_sig_q (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .ok_raw(sig_ok_raw[ch]), .hold_off(suspend), .lost(sig_lost[ch])
    );
    chp_loss_qual #(.QUAL_TICKS(QUAL_TICKS)) u_exc_q (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .ok_raw(exc_ok_raw[ch]), .hold_off(suspend), .lost(exc_lost[ch])
    );
  end

  assign fail_vec[KIND_SIG]  = sig_lost;
  assign fail_vec[KIND_EXC]  = exc_lost;
  assign fail_vec[KIND_TEST] = ~test_ok_raw & {NUM_CH{test_running}};
  assign rd_vec[KIND_SIG]    = rd_sig_stat;
  assign rd_vec[KIND_EXC]    = rd_exc_stat;
  assign rd_vec[KIND_TEST]   = rd_test_stat;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_stat
    chp_sticky_status #(.NUM_CH(NUM_CH)) u_sticky (
      .clk(clk), .rst_n(rst_n),
      .fail_now(fail_vec[k]), .active(active_mask), .rd_release(rd_vec[k]),
      .status(stat_vec[k]), .new_fail(rise_vec[k])
    );
  end

  assign sig_stat  = stat_vec[KIND_SIG];
  assign exc_stat  = stat_vec[KIND_EXC];
  assign test_stat = stat_vec[KIND_TEST];

  always_comb begin
    cause_evt             = '0;
    cause_evt[CAUSE_SIG]  = |rise_vec[KIND_SIG];
    cause_evt[CAUSE_EXC]  = |rise_vec[KIND_EXC];
    cause_evt[CAUSE_TEST] = |rise_vec[KIND_TEST];
  end

  chp_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .cause_evt(cause_evt),
    .en_wr(irq_en_wr), .en_wdata(irq_en_wdata), .rd_stat(rd_irq_stat),
    .stat(irq_stat), .enable(irq_enable), .irq(irq_out)
  );

  chp_verify_reg u_verify (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bg_on(bg_test_en),
    .wr(verify_wr), .wdata(verify_wdata), .value(verify_reg)
  );
endmodule

// File: rtl/chan_health_chk.sv
module chan_health_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [NUM_CH-1:0] active_mask,
  input logic              bg_test_en,
  input logic              init_test_en,
  input logic              loop_test_en,
  input logic              rd_sig_stat,
  input logic              rd_exc_stat,
  input logic              verify_wr,
  input logic [NUM_CH-1:0] sig_stat,
  input logic [NUM_CH-1:0] exc_stat,
  input logic [NUM_CH-1:0] test_stat,
  input logic [3:0]        irq_stat,
  input logic [3:0]        irq_enable,
  input logic [7:0]        verify_reg,
  input logic              irq_out
);
  AST_INACTIVE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((sig_stat | exc_stat | test_stat) & ~active_mask) == '0); // R2

  AST_SIG_HELD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sig_stat |=> ((sig_stat & $past(~sig_stat) & $past(active_mask)) == '0)); // R4

  AST_EXC_HELD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_exc_stat |=> ((exc_stat & $past(~exc_stat) & $past(active_mask)) == '0)); // R4

  AST_SUSPEND_SIG_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ((init_test_en || loop_test_en) && rd_sig_stat)
      |=> (!(init_test_en || loop_test_en) || (sig_stat == active_mask))); // R7

  AST_SUSPEND_EXC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ((init_test_en || loop_test_en) && rd_exc_stat)
      |=> (!(init_test_en || loop_test_en) || (exc_stat == active_mask))); // R7

  AST_CAUSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stat & ~$past(irq_stat) & ~$past(irq_enable)) == 4'b0000); // R5

  AST_VERIFY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_test_en && tick && !verify_wr) |=> (verify_reg == 8'h55)); // R8

  AST_LINE_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enable == 4'b0000) |-> !irq_out); // R11
endmodule

bind chan_health_irq chan_health_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .active_mask(active_mask),
  .bg_test_en(bg_test_en), .init_test_en(init_test_en), .loop_test_en(loop_test_en),
  .rd_sig_stat(rd_sig_stat), .rd_exc_stat(rd_exc_stat), .verify_wr(verify_wr),
  .sig_stat(sig_stat), .exc_stat(exc_stat), .test_stat(test_stat),
  .irq_stat(irq_stat), .irq_enable(irq_enable), .verify_reg(verify_reg),
  .irq_out(irq_out)
);

// File: tb/chan_health_irq_test.sv
module chan_health_irq_test;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] sig_ok_raw = 8'hFF, exc_ok_raw = 8'hFF, test_ok_raw = 8'hFF;
  logic [7:0] active_mask = 8'h00;
  logic       bg_test_en = 1'b0, init_test_en = 1'b0, loop_test_en = 1'b0;
  logic       rd_sig_stat = 1'b0, rd_exc_stat = 1'b0, rd_test_stat = 1'b0, rd_irq_stat = 1'b0;
  logic       irq_en_wr = 1'b0;
  logic [3:0] irq_en_wdata = 4'h0;
  logic       verify_wr = 1'b0;
  logic [7:0] verify_wdata = 8'h00;
  logic [7:0] sig_stat, exc_stat, test_stat, verify_reg;
  logic [3:0] irq_stat, irq_enable;
  logic       irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  chan_health_irq #(.NUM_CH(8), .QUAL_TICKS(Q)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .sig_ok_raw(sig_ok_raw), .exc_ok_raw(exc_ok_raw), .test_ok_raw(test_ok_raw),
    .active_mask(active_mask), .bg_test_en(bg_test_en), .init_test_en(init_test_en),
    .loop_test_en(loop_test_en), .rd_sig_stat(rd_sig_stat), .rd_exc_stat(rd_exc_stat),
    .rd_test_stat(rd_test_stat), .rd_irq_stat(rd_irq_stat), .irq_en_wr(irq_en_wr),
    .irq_en_wdata(irq_en_wdata), .verify_wr(verify_wr), .verify_wdata(verify_wdata),
    .sig_stat(sig_stat), .exc_stat(exc_stat), .test_stat(test_stat),
    .irq_stat(irq_stat), .irq_enable(irq_enable), .verify_reg(verify_reg), .irq_out(irq_out)
  );

  // behavioural reference state
  int         m_cs [8];
  int         m_ce [8];
  logic [7:0] m_ls = 0, m_le = 0, m_lt = 0;
  logic [7:0] m_ps = 0, m_pe = 0, m_pt = 0;
  logic [3:0] m_irq = 0, m_en = 0;
  logic [7:0] m_ver = 0;

  function automatic logic [7:0] f_sig();
    logic [7:0] f = 0;
    for (int i = 0; i < 8; i++)
      f[i] = (m_cs[i] == Q) && !(init_test_en || loop_test_en);
    return f;
  endfunction

  function automatic logic [7:0] f_exc();
    logic [7:0] f = 0;
    for (int i = 0; i < 8; i++)
      f[i] = (m_ce[i] == Q) && !(init_test_en || loop_test_en);
    return f;
  endfunction

  function automatic logic [7:0] f_test();
    return (bg_test_en || init_test_en) ? ~test_ok_raw : 8'h00;
  endfunction

  always @(posedge clk) begin : model
    logic [7:0] fs, fe, ft;
    logic [3:0] nirq;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_cs[i] = 0; m_ce[i] = 0; end
      m_ls = 0; m_le = 0; m_lt = 0; m_ps = 0; m_pe = 0; m_pt = 0;
      m_irq = 0; m_en = 0; m_ver = 0;
    end else begin
      fs = f_sig(); fe = f_exc(); ft = f_test();
      nirq = m_irq & ~{4{rd_irq_stat}};
      if ((|(fs & ~m_ps & active_mask)) && m_en[0]) nirq[0] = 1'b1;
      if ((|(fe & ~m_pe & active_mask)) && m_en[1]) nirq[1] = 1'b1;
      if ((|(ft & ~m_pt & active_mask)) && m_en[3]) nirq[3] = 1'b1;
      m_irq = nirq;
      m_ls = fs | (m_ls & ~{8{rd_sig_stat}});
      m_le = fe | (m_le & ~{8{rd_exc_stat}});
      m_lt = ft | (m_lt & ~{8{rd_test_stat}});
      m_ps = fs; m_pe = fe; m_pt = ft;
      for (int i = 0; i < 8; i++) begin
        if (sig_ok_raw[i] || init_test_en || loop_test_en) m_cs[i] = 0;
        else if (tick && m_cs[i] < Q) m_cs[i] = m_cs[i] + 1;
        if (exc_ok_raw[i] || init_test_en || loop_test_en) m_ce[i] = 0;
        else if (tick && m_ce[i] < Q) m_ce[i] = m_ce[i] + 1;
      end
      if (irq_en_wr) m_en = irq_en_wdata & 4'b1011;
      if (verify_wr) m_ver = verify_wdata;
      else if (bg_test_en && tick) m_ver = 8'h55;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    if (rst_n) begin
      chk("R1/R2/R3/R4 sig_stat", sig_stat, active_mask & ~(m_ls | f_sig()));
      chk("R1/R2/R3/R4 exc_stat", exc_stat, active_mask & ~(m_le | f_exc()));
      chk("R9/R10 test_stat", test_stat, active_mask & ~(m_lt | f_test()));
      chk("R5/R6 irq_stat", {4'h0, irq_stat}, {4'h0, m_irq});
      chk("R5 irq_enable", {4'h0, irq_enable}, {4'h0, m_en});
      chk("R8 verify_reg", verify_reg, m_ver);
      chk("R11 irq_out", {7'h0, irq_out}, {7'h0, |(m_irq & m_en)});
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset sig_stat", sig_stat, 8'h00);
    chk("R6 reset irq_stat", {4'h0, irq_stat}, 8'h00);
    chk("R8 reset verify", verify_reg, 8'h00);
    active_mask = 8'hFF; step(1);
    chk("R1 all healthy", sig_stat, 8'hFF);
    active_mask = 8'h7F; step(1);
    chk("R2 masked channel", sig_stat, 8'h7F);
    active_mask = 8'hFF;
    irq_en_wr = 1; irq_en_wdata = 4'b1111; step(1); irq_en_wr = 0;
    chk("R5 enable bit2 dropped", {4'h0, irq_enable}, 8'h0B);
    irq_en_wr = 1; irq_en_wdata = 4'b1001; step(1); irq_en_wr = 0;
    // R3 qualification on channel 3
    tick = 1; sig_ok_raw[2] = 0; step(Q - 1);
    chk("R3 before qualification", sig_stat, 8'hFF);
    step(1);
    chk("R3 after qualification", sig_stat, 8'hFB);
    step(1);
    chk("R5 signal cause bit0", {4'h0, irq_stat}, 8'h01);
    chk("R11 line raised", {7'h0, irq_out}, 8'h01);
    sig_ok_raw[2] = 1; step(2);
    chk("R4 latched after recovery", sig_stat, 8'hFB);
    rd_sig_stat = 1; step(1); rd_sig_stat = 0;
    chk("R4 released by read", sig_stat, 8'hFF);
    rd_irq_stat = 1; step(1);
    chk("R6 cleared by read", {4'h0, irq_stat}, 8'h00);
    step(1); rd_irq_stat = 0;
    chk("R6 second read clear", {4'h0, irq_stat}, 8'h00);
    chk("R11 line low", {7'h0, irq_out}, 8'h00);
    // R3 restart
    exc_ok_raw[0] = 0; step(Q - 1); exc_ok_raw[0] = 1; step(1);
    exc_ok_raw[0] = 0; step(Q - 1);
    chk("R3 count restarted", exc_stat, 8'hFF);
    exc_ok_raw[0] = 1; step(1);
    // R5 disabled cause
    exc_ok_raw[4] = 0; step(Q + 2);
    chk("R5 exc loss latched", exc_stat, 8'hEF);
    chk("R5 disabled cause stays 0", {4'h0, irq_stat}, 8'h00);
    exc_ok_raw[4] = 1; step(1);
    rd_exc_stat = 1; step(1); rd_exc_stat = 0;
    chk("R4 exc released", exc_stat, 8'hFF);
    // R10 failure wins over read
    sig_ok_raw[3] = 0; step(Q);
    chk("R10 setup", sig_stat, 8'hF7);
    sig_ok_raw[3] = 1; rd_sig_stat = 1; step(1); rd_sig_stat = 0;
    chk("R10 failure wins", sig_stat, 8'hF7);
    rd_sig_stat = 1; rd_irq_stat = 1; step(1); rd_sig_stat = 0; rd_irq_stat = 0;
    chk("R10 later read releases", sig_stat, 8'hFF);
    // R7 suspension
    loop_test_en = 1; sig_ok_raw[0] = 0; exc_ok_raw[0] = 0; step(3 * Q);
    chk("R7 signal ignored in loop test", sig_stat, 8'hFF);
    chk("R7 excitation ignored", exc_stat, 8'hFF);
    loop_test_en = 0; init_test_en = 1; step(3 * Q);
    chk("R7 ignored in init test", sig_stat, 8'hFF);
    sig_ok_raw[0] = 1; exc_ok_raw[0] = 1; init_test_en = 0; step(1);
    // R8 verify
    tick = 0; bg_test_en = 1; step(1);
    chk("R8 no reload without tick", verify_reg, 8'h00);
    tick = 1; step(1);
    chk("R8 loaded 55h", verify_reg, 8'h55);
    tick = 0; verify_wr = 1; verify_wdata = 8'h00; step(1); verify_wr = 0;
    chk("R8 cleared by write", verify_reg, 8'h00);
    tick = 1; step(1);
    chk("R8 reappears", verify_reg, 8'h55);
    // R9 test accuracy
    test_ok_raw[1] = 0; step(1);
    chk("R9 test failure", test_stat, 8'hFD);
    chk("R5 test cause bit3", {4'h0, irq_stat}, 8'h08);
    test_ok_raw[1] = 1; bg_test_en = 0; step(1);
    rd_test_stat = 1; rd_irq_stat = 1; step(1); rd_test_stat = 0; rd_irq_stat = 0;
    chk("R9 released", test_stat, 8'hFF);
    test_ok_raw = 8'h00; step(2);
    chk("R9 idle ignores input", test_stat, 8'hFF);
    test_ok_raw = 8'hFF;
    // random phase, model compared every cycle
    for (int c = 0; c < 4000; c++) begin
      if (c % 16 == 0) begin
        sig_ok_raw   = ~(8'($urandom) & 8'($urandom));
        exc_ok_raw   = ~(8'($urandom) & 8'($urandom));
        test_ok_raw  = ~(8'($urandom) & 8'($urandom) & 8'($urandom));
        active_mask  = 8'($urandom) | 8'($urandom);
        bg_test_en   = ($urandom % 3) == 0;
        init_test_en = ($urandom % 6) == 0;
        loop_test_en = ($urandom % 6) == 0;
      end
      tick         = ($urandom % 2) == 0;
      rd_sig_stat  = ($urandom % 8) == 0;
      rd_exc_stat  = ($urandom % 8) == 0;
      rd_test_stat = ($urandom % 8) == 0;
      rd_irq_stat  = ($urandom % 6) == 0;
      irq_en_wr    = ($urandom % 40) == 0;
      irq_en_wdata = 4'($urandom);
      verify_wr    = ($urandom % 30) == 0;
      verify_wdata = 8'($urandom);
      step(1);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule